// File: doc/BRIEF.md
# Open-Drain Attention Requester

This block sits in a target device on a shared two-wire bus and lets the device ask the controller for attention without a separate interrupt wire. The device has a pending interrupt or a wish to join the bus. The block either pulls SDA low on an idle bus to begin a transaction itself, or it joins a start that another device has issued. It then places its own header on the bus through an open-drain pull-low output. While the header goes out, it compares the level it drives with the level the wires actually show.

A zero pulls the wire low and a one releases it, so the lowest header wins wherever several senders overlap. A sender that reads back a zero where it released the wire steps aside for the rest of the transaction. Once the header is through, the block samples the controller's answer on the ninth clock. When an interrupt is accepted, it streams its payload bytes from an external source. Each payload byte is followed by a continuation bit.

SCL and SDA arrive already synchronous to a faster system clock. The block finds bus edges by comparing each sample with the previous one. Two strobes from a command decoder set and clear an event-enable flag, which gates interrupt requests.

Top module: `arb_irq_requester`

## Requirements
- R1: With a permitted request pending, the block in its idle state, and both SCL and SDA high, the block asserts `sda_pull_o` on the next clock edge and so issues a start itself.
- R2: If another device issues a start (SDA falls while SCL is high) while a permitted request is pending, the block takes part in that transaction's header without first pulling SDA low itself.
- R3: The header is eight bits sent MSB first. For an interrupt it is the 7-bit dynamic address followed by a 1. For a join request it is address 0x02 followed by a 0. A 0 bit asserts `sda_pull_o` and a 1 bit releases it. `sda_pull_o` only changes in the clock after SCL falls, except when the block issues its own start.
- R4: When a released header bit reads back low at the SCL rising edge, the block pulses `lost_o` for one cycle. It then keeps `sda_pull_o` low until a stop condition (SDA rises while SCL is high) has been seen.
- R5: Another device that sends an identical header at the same moment does not cause a loss.
- R6: On the ninth clock the block releases SDA. A low level there pulses `acked_o`, and a high level pulses `nacked_o`. After a NACK, a request that is still pending is raised again as soon as a stop has returned the bus to idle.
- R7: After an accepted interrupt, the block sends bytes from `pl_data_i` MSB first. It pulses `pl_next_o` once as each byte is taken. Each byte is followed by a continuation bit, which is 1 when `pl_last_i` was low for that byte and 0 on the last byte.
- R8: After the last continuation bit, or after an accepted join request (which carries no payload), the block releases SDA at the next SCL fall and pulses `done_o`.
- R9: The event-enable flag is 1 after reset. `evt_set_i` sets it and `evt_clr_i` clears it, and a clear wins over a set in the same cycle. While the flag is 0, no interrupt request is raised.
- R10: An interrupt is requested only while `has_da_i` is 1. A join request is requested only while `has_da_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronous sample of the bus clock line |
| sda_i | input | 1 | Synchronous sample of the bus data line |
| irq_pend_i | input | 1 | Interrupt pending (level) |
| join_pend_i | input | 1 | Request to join the bus (level) |
| has_da_i | input | 1 | A dynamic address is currently held |
| dyn_addr_i | input | 7 | Dynamic address used in the interrupt header |
| evt_set_i | input | 1 | Strobe that sets the event-enable flag |
| evt_clr_i | input | 1 | Strobe that clears the event-enable flag |
| pl_data_i | input | 8 | Current payload byte |
| pl_last_i | input | 1 | Current payload byte is the last one |
| sda_pull_o | output | 1 | Pull SDA low (open-drain enable) |
| pl_next_o | output | 1 | Payload byte taken, one-cycle pulse |
| lost_o | output | 1 | Arbitration lost, one-cycle pulse |
| acked_o | output | 1 | Request acknowledged, one-cycle pulse |
| nacked_o | output | 1 | Request refused, one-cycle pulse |
| done_o | output | 1 | Transfer finished and SDA released, one-cycle pulse |
| busy_o | output | 1 | Taking part in a transaction |
| evt_en_o | output | 1 | Event-enable flag |

## Verification
The bench models a wired-AND bus in which the controller and a second target each back off once they lose arbitration, so overlapping headers resolve the same way real wires would. It checks the case where the block loses in the middle of the header and a later bit of the winner differs. A design that kept driving after losing would corrupt the winner's header, and a design that never detected the loss would never pulse `lost_o`. It checks a NACK followed by a stop: a design that gave up would never pull SDA again, and one that ignored the stop would retry on a busy bus. It checks continuation bits across a two-byte payload, where swapping the polarity would cut the transfer short or run it on, and the enable and address-held gates, where a leak would let SDA fall with no permitted request.

// File: rtl/arb_irq_pkg.sv
package arb_irq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HDR,
    ST_ACK,
    ST_DATA,
    ST_REL
  } arb_state_e;
endpackage

// File: rtl/arb_bus_cond.sv
module arb_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/arb_evt_flag.sv
module arb_evt_flag #(
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_o <= RESET_VAL;
    else if (clr_i) en_o <= 1'b0;
    else if (set_i) en_o <= 1'b1;
  end
endmodule

// File: rtl/arb_irq_requester.sv
module arb_irq_requester
  import arb_irq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] JOIN_ADDR = 7'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              irq_pend_i,
  input  logic              join_pend_i,
  input  logic              has_da_i,
  input  logic [ADDR_W-1:0] dyn_addr_i,
  input  logic              evt_set_i,
  input  logic              evt_clr_i,
  input  logic [DATA_W-1:0] pl_data_i,
  input  logic              pl_last_i,
  output logic              sda_pull_o,
  output logic              pl_next_o,
  output logic              lost_o,
  output logic              acked_o,
  output logic              nacked_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              evt_en_o
);
  localparam int HDR_W  = ADDR_W + 1;
  localparam int HCNT_W = $clog2(HDR_W);
  localparam int DCNT_W = $clog2(DATA_W + 1);

  logic scl_rise, scl_fall, start_c, stop_c;
  logic want, want_ibi, want_hj;
  logic [HDR_W-1:0]  hdr_d, hsh_q;
  logic [HCNT_W-1:0] hcnt_q;
  logic [DCNT_W-1:0] dcnt_q;
  logic [DATA_W-1:0] dsh_q;
  logic              last_q, hj_q, pull_q;
  arb_state_e        st_q;

  arb_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  arb_evt_flag #(.RESET_VAL(1'b1)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set_i),
    .clr_i  (evt_clr_i),
    .en_o   (evt_en_o)
  );

  assign want_ibi = irq_pend_i & has_da_i & evt_en_o;
  assign want_hj  = join_pend_i & ~has_da_i;
  assign want     = want_ibi | want_hj;
  assign hdr_d    = has_da_i ? {dyn_addr_i, 1'b1} : {JOIN_ADDR, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      pull_q    <= 1'b0;
      hsh_q     <= '0;
      hcnt_q    <= '0;
      dcnt_q    <= '0;
      dsh_q     <= '0;
      last_q    <= 1'b0;
      hj_q      <= 1'b0;
      lost_o    <= 1'b0;
      acked_o   <= 1'b0;
      nacked_o  <= 1'b0;
      done_o    <= 1'b0;
      pl_next_o <= 1'b0;
    end else begin
      lost_o    <= 1'b0;
      acked_o   <= 1'b0;
      nacked_o  <= 1'b0;
      done_o    <= 1'b0;
      pl_next_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_c) begin
            // own start or a foreign one we join
            if (want || pull_q) begin
              st_q   <= ST_HDR;
              hsh_q  <= hdr_d;
              hj_q   <= ~has_da_i;
              hcnt_q <= '0;
            end else begin
              st_q <= ST_WAIT;
            end
          end else if (want && scl_i && sda_i) begin
            pull_q <= 1'b1;
          end
        end
        ST_WAIT: if (stop_c) st_q <= ST_IDLE;
        ST_HDR: begin
          if (stop_c) begin
            st_q   <= ST_IDLE;
            pull_q <= 1'b0;
          end else if (scl_fall) begin
            pull_q <= ~hsh_q[HDR_W-1];
          end else if (scl_rise) begin
            if (hsh_q[HDR_W-1] && !sda_i) begin
              lost_o <= 1'b1;
              pull_q <= 1'b0;
              st_q   <= ST_WAIT;
            end else if (hcnt_q == HCNT_W'(HDR_W - 1)) begin
              st_q <= ST_ACK;
            end else begin
              hcnt_q <= hcnt_q + 1'b1;
              hsh_q  <= {hsh_q[HDR_W-2:0], 1'b0};
            end
          end
        end
        ST_ACK: begin
          if (stop_c) begin
            st_q   <= ST_IDLE;
            pull_q <= 1'b0;
          end else if (scl_fall) begin
            pull_q <= 1'b0;
          end else if (scl_rise) begin
            if (!sda_i) begin
              acked_o <= 1'b1;
              dcnt_q  <= '0;
              st_q    <= hj_q ? ST_REL : ST_DATA;
            end else begin
              nacked_o <= 1'b1;
              st_q     <= ST_WAIT;
            end
          end
        end
        ST_DATA: begin
          if (stop_c) begin
            st_q   <= ST_IDLE;
            pull_q <= 1'b0;
          end else if (scl_fall) begin
            if (dcnt_q == '0) begin
              dsh_q     <= {pl_data_i[DATA_W-2:0], 1'b0};
              last_q    <= pl_last_i;
              pull_q    <= ~pl_data_i[DATA_W-1];
              pl_next_o <= 1'b1;
            end else if (dcnt_q < DCNT_W'(DATA_W)) begin
              pull_q <= ~dsh_q[DATA_W-1];
              dsh_q  <= {dsh_q[DATA_W-2:0], 1'b0};
            end else begin
              // continuation bit: 1 = more follows
              pull_q <= last_q;
            end
          end else if (scl_rise) begin
            if (dcnt_q == DCNT_W'(DATA_W)) begin
              if (last_q) st_q <= ST_REL;
              dcnt_q <= '0;
            end else begin
              dcnt_q <= dcnt_q + 1'b1;
            end
          end
        end
        ST_REL: begin
          if (stop_c) begin
            st_q   <= ST_IDLE;
            pull_q <= 1'b0;
          end else if (scl_fall) begin
            pull_q <= 1'b0;
            done_o <= 1'b1;
            st_q   <= ST_WAIT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_pull_o = pull_q;
  assign busy_o     = (st_q != ST_IDLE) && (st_q != ST_WAIT);
endmodule

// File: rtl/arb_irq_requester_chk.sv
module arb_irq_requester_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic irq_pend_i,
  input logic join_pend_i,
  input logic has_da_i,
  input logic sda_pull_o,
  input logic lost_o,
  input logic acked_o,
  input logic nacked_o,
  input logic evt_en_o
);
  // R3
  release_on_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pull_o) |-> !$past(scl_i));

  // R1
  own_start_on_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_pull_o) && $past(scl_i)) |-> $past(sda_i));

  // R9
  gated_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_pull_o) && $past(scl_i)) |->
      $past(has_da_i ? (irq_pend_i && evt_en_o) : join_pend_i));

  // R4
  lost_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |=> !lost_o);

  // R4
  lost_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> !sda_pull_o);

  // R6
  outcome_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lost_o, acked_o, nacked_o}));
endmodule

bind arb_irq_requester arb_irq_requester_chk u_chk (.*);

// File: tb/arb_irq_requester_test.sv
`timescale 1ns/1ps
module arb_irq_requester_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic ctl_pull = 1'b0, oth_pull = 1'b0;
  logic sda;
  logic irq_pend = 0, join_pend = 0, has_da = 1;
  logic [6:0] dyn_addr = 7'h26;
  logic evt_set = 0, evt_clr = 0;
  logic [7:0] pl_data;
  logic pl_last;
  logic sda_pull, pl_next, lost, acked, nacked, done, busy, evt_en;

  int checks = 0, errors = 0;
  int lost_cnt = 0, ack_cnt = 0, nack_cnt = 0, done_cnt = 0, next_cnt = 0;
  int next_base = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign sda = ~(ctl_pull | oth_pull | sda_pull);
  assign pl_data = (next_cnt - next_base == 0) ? 8'hA5 : 8'h3C;
  assign pl_last = (next_cnt - next_base != 0);

  arb_irq_requester uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .irq_pend_i(irq_pend), .join_pend_i(join_pend), .has_da_i(has_da),
    .dyn_addr_i(dyn_addr), .evt_set_i(evt_set), .evt_clr_i(evt_clr),
    .pl_data_i(pl_data), .pl_last_i(pl_last),
    .sda_pull_o(sda_pull), .pl_next_o(pl_next), .lost_o(lost),
    .acked_o(acked), .nacked_o(nacked), .done_o(done), .busy_o(busy),
    .evt_en_o(evt_en)
  );

  always @(posedge clk) begin
    if (lost)    lost_cnt <= lost_cnt + 1;
    if (acked)   ack_cnt  <= ack_cnt + 1;
    if (nacked)  nack_cnt <= nack_cnt + 1;
    if (done)    done_cnt <= done_cnt + 1;
    if (pl_next) next_cnt <= next_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCL period; c_rel/o_rel = 1 releases that driver
  task automatic bit_cycle(input logic c_rel, input logic o_rel, output logic s);
    @(negedge clk) scl = 1'b0;
    wait_cyc(2);
    ctl_pull = ~c_rel;
    oth_pull = ~o_rel;
    wait_cyc(2);
    scl = 1'b1;
    wait_cyc(2);
    s = sda;
    wait_cyc(2);
  endtask

  // wired-AND header; controller and other target yield when they lose
  task automatic send_header(input logic [7:0] c_hdr, input logic [7:0] o_hdr,
                             output logic [7:0] got);
    bit c_out = 0, o_out = 0;
    logic s, cb, ob;
    for (int i = 7; i >= 0; i--) begin
      cb = c_out ? 1'b1 : c_hdr[i];
      ob = o_out ? 1'b1 : o_hdr[i];
      bit_cycle(cb, ob, s);
      got[i] = s;
      if (cb && !s) c_out = 1;
      if (ob && !s) o_out = 1;
    end
  endtask

  task automatic read_byte(output logic [7:0] b, output logic t);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, 1'b1, s);
      b[i] = s;
    end
    bit_cycle(1'b1, 1'b1, t);
  endtask

  task automatic ctl_start;
    @(negedge clk) ctl_pull = 1'b1;
    wait_cyc(4);
  endtask

  task automatic ctl_stop;
    @(negedge clk) scl = 1'b0;
    wait_cyc(2);
    ctl_pull = 1'b1;
    oth_pull = 1'b0;
    wait_cyc(2);
    scl = 1'b1;
    wait_cyc(2);
    ctl_pull = 1'b0;
    wait_cyc(4);
  endtask

  task automatic read_payload(input string req);
    logic [7:0] b;
    logic t;
    int d0;
    d0 = done_cnt;
    read_byte(b, t);
    chk(b == 8'hA5, {req, " byte0"}, b, 8'hA5);
    chk(t == 1'b1, {req, " cont0"}, t, 1);
    read_byte(b, t);
    chk(b == 8'h3C, {req, " byte1"}, b, 8'h3C);
    chk(t == 1'b0, {req, " cont1"}, t, 0);
    ctl_stop();
    chk(done_cnt == d0 + 1, "R8 done after last", done_cnt, d0 + 1);
    chk(sda_pull == 1'b0, "R8 released", sda_pull, 0);
  endtask

  task automatic t_reset;
    chk(sda_pull == 1'b0, "R1 reset pull", sda_pull, 0);
    chk(evt_en == 1'b1, "R9 reset enable", evt_en, 1);
    chk(busy == 1'b0, "R2 reset busy", busy, 0);
  endtask

  task automatic t_ibi_self;
    logic [7:0] got;
    logic s;
    int a0;
    a0 = ack_cnt;
    next_base = next_cnt;
    has_da = 1; dyn_addr = 7'h26;
    @(negedge clk) irq_pend = 1;
    wait_cyc(2);
    chk(sda == 1'b0 && sda_pull, "R1 own start", sda, 0);
    send_header(8'hFF, 8'hFF, got);
    chk(got == 8'h4D, "R3 ibi header", got, 8'h4D);
    bit_cycle(1'b0, 1'b1, s);
    chk(ack_cnt == a0 + 1, "R6 ack seen", ack_cnt, a0 + 1);
    irq_pend = 0;
    read_payload("R7 self");
    chk(next_cnt - next_base == 2, "R7 next pulses", next_cnt - next_base, 2);
  endtask

  task automatic t_nack_retry;
    logic [7:0] got;
    logic s;
    int n0;
    n0 = nack_cnt;
    @(negedge clk) irq_pend = 1;
    wait_cyc(2);
    send_header(8'hFF, 8'hFF, got);
    bit_cycle(1'b1, 1'b1, s);
    chk(s == 1'b1 && nack_cnt == n0 + 1, "R6 nack seen", nack_cnt, n0 + 1);
    chk(sda_pull == 1'b0, "R6 released after nack", sda_pull, 0);
    ctl_stop();
    chk(sda == 1'b0 && sda_pull, "R6 retry after stop", sda, 0);
    send_header(8'hFF, 8'hFF, got);
    chk(got == 8'h4D, "R6 retry header", got, 8'h4D);
    bit_cycle(1'b1, 1'b1, s);
    irq_pend = 0;
    ctl_stop();
    chk(sda_pull == 1'b0, "R6 quiet after drop", sda_pull, 0);
  endtask

  task automatic t_join;
    logic [7:0] got;
    logic s;
    int l0;
    l0 = lost_cnt;
    next_base = next_cnt;
    @(negedge clk) begin irq_pend = 1; ctl_pull = 1; end
    wait_cyc(3);
    chk(sda_pull == 1'b0 && busy, "R2 joined foreign start", sda_pull, 0);
    send_header(8'hFC, 8'hFF, got);
    chk(got == 8'h4D && lost_cnt == l0, "R2 wins over 0x7E", got, 8'h4D);
    bit_cycle(1'b0, 1'b1, s);
    irq_pend = 0;
    read_payload("R7 join");
  endtask

  task automatic t_lost;
    logic [7:0] got;
    logic s;
    int l0;
    l0 = lost_cnt;
    @(negedge clk) irq_pend = 1;
    wait_cyc(2);
    send_header(8'hFF, 8'h47, got);
    chk(lost_cnt == l0 + 1, "R4 lost pulse", lost_cnt, l0 + 1);
    chk(got == 8'h47, "R4 winner header intact", got, 8'h47);
    bit_cycle(1'b0, 1'b1, s);
    chk(sda_pull == 1'b0 && !busy, "R4 stays off bus", sda_pull, 0);
    irq_pend = 0;
    ctl_stop();
  endtask

  task automatic t_hotjoin;
    logic [7:0] got;
    logic s;
    int l0, d0, n0;
    l0 = lost_cnt; d0 = done_cnt; n0 = next_cnt;
    has_da = 0;
    @(negedge clk) join_pend = 1;
    wait_cyc(2);
    chk(sda == 1'b0, "R10 join start without address", sda, 0);
    send_header(8'hFF, 8'h04, got);
    chk(got == 8'h04, "R3 join header", got, 8'h04);
    chk(lost_cnt == l0, "R5 identical header no loss", lost_cnt, l0);
    bit_cycle(1'b0, 1'b1, s);
    join_pend = 0;
    ctl_stop();
    chk(done_cnt == d0 + 1 && next_cnt == n0, "R8 join done, no payload", done_cnt, d0 + 1);
    has_da = 1;
  endtask

  task automatic t_enable;
    @(negedge clk) evt_clr = 1;
    @(negedge clk) begin evt_clr = 0; irq_pend = 1; end
    wait_cyc(10);
    chk(sda_pull == 1'b0 && sda, "R9 blocked while disabled", sda_pull, 0);
    chk(evt_en == 1'b0, "R9 cleared", evt_en, 0);
    @(negedge clk) begin irq_pend = 0; evt_set = 1; evt_clr = 1; end
    @(negedge clk) begin evt_set = 0; evt_clr = 0; end
    chk(evt_en == 1'b0, "R9 clear wins", evt_en, 0);
    @(negedge clk) evt_set = 1;
    @(negedge clk) evt_set = 0;
    chk(evt_en == 1'b1, "R9 set", evt_en, 1);
  endtask

  task automatic t_select;
    @(negedge clk) begin has_da = 0; irq_pend = 1; join_pend = 0; end
    wait_cyc(8);
    chk(sda_pull == 1'b0, "R10 no irq without address", sda_pull, 0);
    @(negedge clk) begin has_da = 1; irq_pend = 0; join_pend = 1; end
    wait_cyc(8);
    chk(sda_pull == 1'b0, "R10 no join with address", sda_pull, 0);
    @(negedge clk) join_pend = 0;
    wait_cyc(2);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_ibi_self();
    t_nack_retry();
    t_join();
    t_lost();
    t_hotjoin();
    t_enable();
    t_select();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule